// File: doc/BRIEF.md
# Address-Register Arithmetic Unit with Modulo Wrap

This block is the arithmetic part of an address generator. It holds sixteen 32-bit address registers, four offset registers, four modifier registers and a stack pointer. Each accepted operation reads a destination register and a source operand, and writes a result back in one clock. The source operand is either a register or an immediate. The block also updates a single true/false status flag.

For the lowest eight address registers the result of add-type operations passes through a wrap stage. A per-register selector picks one of the modifier registers as a mask. The mask 2^k-1 keeps the upper bits of the old register value and lets the low k bits wrap modulo 2^k, whatever the operand size. A mask of all ones gives plain 32-bit arithmetic. Shifts and compares never use the mask. Compares write only the status flag.

Operations arrive on a valid/ready port. The unit never stalls: ready is high in every cycle outside reset, and it drops only while reset is held. An operation is taken in a cycle where valid and ready are both high. When valid is low, no state changes. A read port shows any register in the same cycle, so results are visible after the clock edge that follows acceptance.

Top module: `addr_arith_unit`

## Requirements
- R1: A synchronous reset sets every register to zero except the modifiers, which become all ones. It also sets every selector to 0 and clears `t_flag`. `in_ready` is low while `rst` is high and high otherwise. State changes only on a cycle with `in_valid` and `in_ready` both high.
- R2: The wrap stage applies to ADD (opcode 2), SUB (3), ADDL1 (4), ADDL2 (5), INC (6), DEC (7) and DECT (8) when the destination is index 0 to 7. With mask M, the bits outside M keep the old destination value. The bits inside M take the corresponding bits of the sum.
- R3: A mask of 2^k-1 gives wrap modulo 2^k on the low k bits for any signed operand, for k from 1 to 31. A mask of 0xFFFFFFFF gives linear arithmetic modulo 2^32.
- R4: Indexes 8 to 24 always use linear arithmetic. MOVE (opcode 1), which copies the operand into the destination, never wraps.
- R5: ADDL1 and ADDL2 shift the operand left by 1 and by 2 bits before adding. SUB subtracts the operand, INC adds one and DEC subtracts one.
- R6: ASL1 (9), ASL2 (10) and ASR (11) write the operand, shifted left by 1, shifted left by 2, or shifted right arithmetically by 1, into the destination. The shift is over 32 bits, and the mask has no effect.
- R7: CMPEQ (12), CMPGT (13) and CMPHI (14) set `t_flag` to destination == operand, signed destination > operand, and unsigned destination > operand. They write no register.
- R8: DECT decrements the destination and sets `t_flag` to 1 exactly when the written result is zero.
- R9: Every operation other than DECT and the compares leaves `t_flag` unchanged.
- R10: SELM (15) sets the selector of destination register 0 to 7 to operand bits [1:0]. The selector picks modifier index 20 plus that value. SELM with a destination of 8 or above has no effect.
- R11: The register index map is: 0 to 15 address registers, 16 to 19 offset registers, 20 to 23 modifiers, 24 stack pointer. Indexes 25 to 31 read as zero and ignore writes.
- R12: When `in_use_imm` is 1 the operand is `in_imm`. When it is 0 the operand is the register at `in_src`, offset registers included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be taken (high outside reset) |
| in_op | input | 4 | Opcode |
| in_dst | input | 5 | Destination register index |
| in_src | input | 5 | Source register index |
| in_use_imm | input | 1 | Select immediate as operand |
| in_imm | input | 32 | Immediate operand |
| rd_idx | input | 5 | Observation read index |
| rd_data | output | 32 | Register value at `rd_idx` |
| t_flag | output | 1 | Status flag |

## Verification
The bench sweeps signed offsets across every add-type opcode and several masks, from 2^1-1 up to 2^31-1 and all ones. The bases it uses sit just below a wrap boundary and have set upper bits. A wrap stage that let carries leak above the mask would change upper bits, and one built on a true remainder would get negative offsets wrong. Compares run over all pairs taken from signed and unsigned extreme values, so a design that swapped the signed and unsigned test would fail on 0x7FFFFFFF against 0x80000000. Further checks catch errors in other parts of the block. A shift that used the mask, a flag touched by a non-test operation, a write to an unused index, and a selector write for a high register would each show up on the read port.

// File: rtl/aau_pkg.sv
package aau_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_MOVE  = 4'd1,
    OP_ADD   = 4'd2,
    OP_SUB   = 4'd3,
    OP_ADDL1 = 4'd4,
    OP_ADDL2 = 4'd5,
    OP_INC   = 4'd6,
    OP_DEC   = 4'd7,
    OP_DECT  = 4'd8,
    OP_ASL1  = 4'd9,
    OP_ASL2  = 4'd10,
    OP_ASR   = 4'd11,
    OP_CMPEQ = 4'd12,
    OP_CMPGT = 4'd13,
    OP_CMPHI = 4'd14,
    OP_SELM  = 4'd15
  } aau_op_e;

  function automatic logic op_is_cmp(aau_op_e op);
    return (op == OP_CMPEQ) || (op == OP_CMPGT) || (op == OP_CMPHI);
  endfunction

  function automatic logic op_sets_t(aau_op_e op);
    return op_is_cmp(op) || (op == OP_DECT);
  endfunction

endpackage

// File: rtl/aau_regfile.sv
module aau_regfile #(
  parameter int XLEN     = 32,
  parameter int NUM_AREG = 16,
  parameter int NUM_OFS  = 4,
  parameter int NUM_MOD  = 4,
  parameter int NUM_LOW  = 8,
  parameter int IDW      = 5,
  parameter int MSW      = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IDW-1:0]  wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            sel_we,
  input  logic [IDW-1:0]  sel_idx,
  input  logic [MSW-1:0]  sel_val,
  input  logic [IDW-1:0]  ra_idx,
  output logic [XLEN-1:0] ra_data,
  input  logic [IDW-1:0]  rb_idx,
  output logic [XLEN-1:0] rb_data,
  input  logic [IDW-1:0]  rc_idx,
  output logic [XLEN-1:0] rc_data,
  output logic [XLEN-1:0] mask_data,
  output logic            mask_hit
);
  localparam int OFS_BASE = NUM_AREG;
  localparam int MOD_BASE = OFS_BASE + NUM_OFS;
  localparam int SP_IDX   = MOD_BASE + NUM_MOD;
  localparam int NUM_ENT  = SP_IDX + 1;
  localparam int LOWW     = (NUM_LOW > 1) ? $clog2(NUM_LOW) : 1;

  logic [NUM_ENT-1:0][XLEN-1:0] ent;
  logic [NUM_LOW-1:0][MSW-1:0]  sel;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    localparam logic [XLEN-1:0] RST_VAL =
      (g >= MOD_BASE && g < SP_IDX) ? {XLEN{1'b1}} : {XLEN{1'b0}};
    logic [XLEN-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                q <= RST_VAL;
      else if (we && wr_idx == IDW'(g))       q <= wr_data;
    end
    assign ent[g] = q;
  end

  for (genvar s = 0; s < NUM_LOW; s++) begin : g_sel
    logic [MSW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                q <= '0;
      else if (sel_we && sel_idx == IDW'(s))  q <= sel_val;
    end
    assign sel[s] = q;
  end

  function automatic logic [XLEN-1:0] rd(input logic [IDW-1:0] idx,
                                         input logic [NUM_ENT-1:0][XLEN-1:0] arr);
    if (int'(idx) < NUM_ENT) return arr[int'(idx)];
    return '0;
  endfunction

  always_comb begin
    ra_data = rd(ra_idx, ent);
    rb_data = rd(rb_idx, ent);
    rc_data = rd(rc_idx, ent);
  end

  always_comb begin
    mask_hit  = int'(ra_idx) < NUM_LOW;
    mask_data = '1;
    if (mask_hit)
      mask_data = ent[MOD_BASE + int'(sel[ra_idx[LOWW-1:0]])];
  end

endmodule

// File: rtl/aau_alu.sv
module aau_alu
  import aau_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  aau_op_e         op,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  output logic [XLEN-1:0] raw,
  output logic            writes,
  output logic            add_kind,
  output logic            t_we,
  output logic            t_val
);
  logic [XLEN-1:0] addend;

  always_comb begin
    addend   = '0;
    raw      = '0;
    writes   = 1'b0;
    add_kind = 1'b0;
    t_we     = 1'b0;
    t_val    = 1'b0;
    case (op)
      OP_MOVE:  begin raw = src_val; writes = 1'b1; end
      OP_ADD:   begin addend = src_val;                    add_kind = 1'b1; end
      OP_SUB:   begin addend = ~src_val + XLEN'(1);        add_kind = 1'b1; end
      OP_ADDL1: begin addend = {src_val[XLEN-2:0], 1'b0};  add_kind = 1'b1; end
      OP_ADDL2: begin addend = {src_val[XLEN-3:0], 2'b00}; add_kind = 1'b1; end
      OP_INC:   begin addend = XLEN'(1);                   add_kind = 1'b1; end
      OP_DEC,
      OP_DECT:  begin addend = '1;                         add_kind = 1'b1; end
      OP_ASL1:  begin raw = {src_val[XLEN-2:0], 1'b0};  writes = 1'b1; end
      OP_ASL2:  begin raw = {src_val[XLEN-3:0], 2'b00}; writes = 1'b1; end
      OP_ASR:   begin raw = {src_val[XLEN-1], src_val[XLEN-1:1]}; writes = 1'b1; end
      OP_CMPEQ: begin t_we = 1'b1; t_val = (dst_val == src_val); end
      OP_CMPGT: begin t_we = 1'b1; t_val = ($signed(dst_val) > $signed(src_val)); end
      OP_CMPHI: begin t_we = 1'b1; t_val = (dst_val > src_val); end
      default:  ;
    endcase
    if (add_kind) begin
      raw    = dst_val + addend;
      writes = 1'b1;
    end
  end

endmodule

// File: rtl/aau_modwrap.sv
module aau_modwrap #(
  parameter int XLEN = 32
) (
  input  logic            en,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] raw,
  input  logic [XLEN-1:0] mask,
  output logic [XLEN-1:0] result
);
  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    assign result[b] = (en && !mask[b]) ? old_val[b] : raw[b];
  end
endmodule

// File: rtl/addr_arith_unit.sv
module addr_arith_unit
  import aau_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_AREG = 16,
  parameter int NUM_OFS  = 4,
  parameter int NUM_MOD  = 4,
  parameter int NUM_LOW  = 8,
  localparam int NUM_ENT = NUM_AREG + NUM_OFS + NUM_MOD + 1,
  localparam int IDW     = $clog2(NUM_ENT),
  localparam int MSW     = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      in_op,
  input  logic [IDW-1:0]  in_dst,
  input  logic [IDW-1:0]  in_src,
  input  logic            in_use_imm,
  input  logic [XLEN-1:0] in_imm,
  input  logic [IDW-1:0]  rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic            t_flag
);
  aau_op_e         op;
  logic            acc;
  logic [XLEN-1:0] dst_val, src_reg, src_val, raw, wr_data, mod_mask;
  logic            writes, add_kind, t_we, t_val, mask_hit, mod_on, wr_en, sel_we;

  assign op       = aau_op_e'(in_op);
  assign in_ready = !rst;
  assign acc      = in_valid && in_ready;
  assign src_val  = in_use_imm ? in_imm : src_reg;

  aau_regfile #(
    .XLEN(XLEN), .NUM_AREG(NUM_AREG), .NUM_OFS(NUM_OFS), .NUM_MOD(NUM_MOD),
    .NUM_LOW(NUM_LOW), .IDW(IDW), .MSW(MSW)
  ) u_rf (
    .clk(clk), .rst(rst),
    .we(wr_en), .wr_idx(in_dst), .wr_data(wr_data),
    .sel_we(sel_we), .sel_idx(in_dst), .sel_val(src_val[MSW-1:0]),
    .ra_idx(in_dst), .ra_data(dst_val),
    .rb_idx(in_src), .rb_data(src_reg),
    .rc_idx(rd_idx), .rc_data(rd_data),
    .mask_data(mod_mask), .mask_hit(mask_hit)
  );

  aau_alu #(.XLEN(XLEN)) u_alu (
    .op(op), .dst_val(dst_val), .src_val(src_val), .raw(raw),
    .writes(writes), .add_kind(add_kind), .t_we(t_we), .t_val(t_val)
  );

  assign mod_on = add_kind && mask_hit;

  aau_modwrap #(.XLEN(XLEN)) u_wrap (
    .en(mod_on), .old_val(dst_val), .raw(raw), .mask(mod_mask), .result(wr_data)
  );

  assign wr_en  = acc && writes && (int'(in_dst) < NUM_ENT);
  assign sel_we = acc && (op == OP_SELM) && (int'(in_dst) < NUM_LOW);

  always_ff @(posedge clk) begin
    if (rst)                         t_flag <= 1'b0;
    else if (acc && op == OP_DECT)   t_flag <= (wr_data == '0);
    else if (acc && t_we)            t_flag <= t_val;
  end

endmodule

// File: rtl/aau_checker.sv
module aau_checker
  import aau_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IDW     = 5,
  parameter int NUM_LOW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            acc,
  input logic [3:0]      in_op,
  input logic            wr_en,
  input logic            mod_on,
  input logic [IDW-1:0]  in_dst,
  input logic [XLEN-1:0] wr_data,
  input logic [XLEN-1:0] dst_val,
  input logic [XLEN-1:0] mod_mask,
  input logic            t_flag
);
  aau_op_e op;
  assign op = aau_op_e'(in_op);

  a_r2_upper_bits_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mod_on) |-> ((wr_data & ~mod_mask) == (dst_val & ~mod_mask)));

  a_r4_high_regs_linear: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(in_dst) >= NUM_LOW) |-> !mod_on);

  a_r7_compare_no_write: assert property (@(posedge clk) disable iff (rst)
    (acc && op_is_cmp(op)) |-> !wr_en);

  a_r8_dect_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_DECT && wr_en) |=> (t_flag == ($past(wr_data) == '0)));

  a_r9_flag_held: assert property (@(posedge clk) disable iff (rst)
    (!acc || !op_sets_t(op)) |=> $stable(t_flag));
endmodule

bind addr_arith_unit aau_checker #(.XLEN(XLEN), .IDW(IDW), .NUM_LOW(NUM_LOW)) u_aau_checker (
  .clk(clk), .rst(rst), .acc(acc), .in_op(in_op), .wr_en(wr_en), .mod_on(mod_on),
  .in_dst(in_dst), .wr_data(wr_data), .dst_val(dst_val), .mod_mask(mod_mask),
  .t_flag(t_flag)
);

// File: tb/addr_arith_unit_bench.sv
`timescale 1ns/1ps
module addr_arith_unit_bench;
  localparam int MOVE = 1, ADD = 2, SUB = 3, ADDL1 = 4, ADDL2 = 5, INC = 6, DEC = 7,
                 DECT = 8, ASL1 = 9, ASL2 = 10, ASR = 11, CMPEQ = 12, CMPGT = 13,
                 CMPHI = 14, SELM = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [4:0]  in_dst = '0, in_src = '0, rd_idx = '0;
  logic        in_use_imm = 1'b0;
  logic [31:0] in_imm = '0;
  logic [31:0] rd_data;
  logic        t_flag;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  addr_arith_unit u_addr_arith_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_dst(in_dst), .in_src(in_src), .in_use_imm(in_use_imm), .in_imm(in_imm),
    .rd_idx(rd_idx), .rd_data(rd_data), .t_flag(t_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input int o, input int d, input int s, input bit ui, input logic [31:0] imm);
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'(o); in_dst = 5'(d); in_src = 5'(s);
    in_use_imm = ui; in_imm = imm;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    rd_idx = 5'(idx);
    #1;
    v = rd_data;
  endtask

  function automatic logic [31:0] wrap_exp(input logic [31:0] base, input longint md, input longint delta);
    longint b, lo;
    b  = longint'(base) % md;
    lo = (b + delta) % md;
    if (lo < 0) lo += md;
    return 32'(longint'(base) - b + lo);
  endfunction

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] masks [6];
    logic [31:0] bases [3];
    logic [31:0] vals  [6];
    masks = '{32'h1, 32'h3, 32'h7, 32'hF, 32'h7FFF_FFFF, 32'hFFFF_FFFF};
    bases = '{32'h1234_5677, 32'hFFFF_FFF3, 32'h0000_0000};
    vals  = '{32'h0, 32'h1, 32'h5, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", 32'(in_ready), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", 32'(in_ready), 32'h1);
    chk("R1 flag reset", 32'(t_flag), 32'h0);
    for (int i = 0; i < 25; i++) begin
      rd(i, v);
      chk("R1 register reset", v, (i >= 20 && i < 24) ? 32'hFFFF_FFFF : 32'h0);
    end

    // R1: valid low changes nothing
    @(negedge clk);
    in_op = 4'(MOVE); in_dst = 5'd0; in_use_imm = 1'b1; in_imm = 32'hDEAD_BEEF;
    @(negedge clk);
    rd(0, v); chk("R1 no accept without valid", v, 32'h0);

    // R2 R3 R5: wrap sweep on R3 through modifier index 21
    issue(SELM, 3, 0, 1, 32'h1);
    foreach (masks[mi]) begin
      longint md;
      md = longint'(masks[mi]) + 1;
      issue(MOVE, 21, 0, 1, masks[mi]);
      foreach (bases[bi]) begin
        for (int o = ADD; o <= DEC; o++) begin
          for (int off = -5; off <= 5; off++) begin
            longint delta;
            if ((o == INC || o == DEC) && off != 0) continue;
            case (o)
              SUB:     delta = -longint'(off);
              ADDL1:   delta = 2 * longint'(off);
              ADDL2:   delta = 4 * longint'(off);
              INC:     delta = 1;
              DEC:     delta = -1;
              default: delta = longint'(off);
            endcase
            issue(MOVE, 3, 0, 1, bases[bi]);
            issue(o, 3, 0, 1, 32'(off));
            rd(3, v);
            chk("R2 R3 R5 wrapped add", v, wrap_exp(bases[bi], md, delta));
          end
        end
      end
    end

    // R4: high register and MOVE stay linear while mask 7 is selected
    issue(MOVE, 21, 0, 1, 32'h7);
    issue(MOVE, 10, 0, 1, 32'hFFFF_FFFE);
    issue(ADD, 10, 0, 1, 32'h5);
    rd(10, v); chk("R4 R10 linear", v, 32'h0000_0003);
    issue(MOVE, 3, 0, 1, 32'hABCD_0123);
    rd(3, v); chk("R4 MOVE not wrapped", v, 32'hABCD_0123);
    issue(MOVE, 24, 0, 1, 32'h0000_1000);
    issue(SUB, 24, 0, 1, 32'h10);
    rd(24, v); chk("R4 stack pointer linear", v, 32'h0000_0FF0);

    // R12: offset register as operand
    issue(MOVE, 18, 0, 1, 32'h10);
    issue(MOVE, 5, 0, 1, 32'h100);
    issue(ADD, 5, 18, 0, 32'hFFFF);
    rd(5, v); chk("R12 offset operand", v, 32'h110);
    issue(ADDL2, 5, 18, 0, 32'h0);
    rd(5, v); chk("R12 R5 offset shifted", v, 32'h150);

    // R6 R9: shifts into R3 ignore mask 7, flag held at 1
    issue(MOVE, 1, 0, 1, 32'h9); issue(CMPEQ, 1, 0, 1, 32'h9);
    foreach (vals[vi]) begin
      issue(MOVE, 6, 0, 1, vals[vi] ^ 32'h1234_5678);
      for (int o = ASL1; o <= ASR; o++) begin
        logic [31:0] x;
        x = vals[vi] ^ 32'h1234_5678;
        issue(o, 3, 6, 0, 32'h0);
        rd(3, v);
        chk("R6 shift", v, (o == ASL1) ? x << 1 : (o == ASL2) ? x << 2 : 32'($signed(x) >>> 1));
        chk("R9 flag held by shift", 32'(t_flag), 32'h1);
      end
    end

    // R7: all pairs
    foreach (vals[ai]) foreach (vals[bi]) begin
      issue(MOVE, 1, 0, 1, vals[ai]);
      issue(MOVE, 2, 0, 1, vals[bi]);
      issue(CMPEQ, 1, 2, 0, 32'h0);
      chk("R7 equal", 32'(t_flag), 32'(vals[ai] == vals[bi]));
      issue(CMPGT, 1, 2, 0, 32'h0);
      chk("R7 signed greater", 32'(t_flag), 32'($signed(vals[ai]) > $signed(vals[bi])));
      issue(CMPHI, 1, 2, 0, 32'h0);
      chk("R7 unsigned higher", 32'(t_flag), 32'(vals[ai] > vals[bi]));
      rd(1, v); chk("R7 no register write", v, vals[ai]);
    end

    // R8
    issue(MOVE, 9, 0, 1, 32'h1); issue(DECT, 9, 0, 1, 32'h0);
    rd(9, v); chk("R8 result", v, 32'h0); chk("R8 zero sets flag", 32'(t_flag), 32'h1);
    issue(DECT, 9, 0, 1, 32'h0);
    rd(9, v); chk("R8 underflow", v, 32'hFFFF_FFFF); chk("R8 nonzero clears", 32'(t_flag), 32'h0);
    issue(MOVE, 3, 0, 1, 32'h8); issue(DECT, 3, 0, 1, 32'h0);
    rd(3, v); chk("R8 wrapped decrement", v, 32'hF); chk("R8 wrapped flag", 32'(t_flag), 32'h0);
    issue(MOVE, 3, 0, 1, 32'h1); issue(DECT, 3, 0, 1, 32'h0);
    chk("R8 wrapped zero", 32'(t_flag), 32'h1);

    // R9: add and move keep flag
    issue(ADD, 3, 0, 1, 32'h3); chk("R9 add keeps flag", 32'(t_flag), 32'h1);
    issue(CMPEQ, 3, 0, 1, 32'h99); issue(MOVE, 3, 0, 1, 32'h0);
    chk("R9 move keeps flag", 32'(t_flag), 32'h0);

    // R10: high destination ignored; low reselect to index 20 gives linear
    issue(SELM, 9, 0, 1, 32'h1);
    issue(MOVE, 9, 0, 1, 32'h7); issue(INC, 9, 0, 1, 32'h0);
    rd(9, v); chk("R10 SELM on R9 ignored", v, 32'h8);
    issue(SELM, 3, 0, 1, 32'h0);
    issue(MOVE, 3, 0, 1, 32'h7); issue(INC, 3, 0, 1, 32'h0);
    rd(3, v); chk("R10 reselect linear", v, 32'h8);

    // R11: unused index
    issue(MOVE, 30, 0, 1, 32'h5);
    rd(30, v); chk("R11 unused reads zero", v, 32'h0);
    rd(14, v); chk("R11 other register untouched", v, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule